// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

This block is a purely combinational shifter for a 16-bit datapath. It takes a data word, a 4-bit shift distance and a 2-bit operation select, and produces the shifted word in the same cycle. It performs a left shift with zero fill, a right shift with zero fill, and a right shift that copies the sign bit into the vacated positions. A fourth operation passes the data through unchanged. A left shift that keeps the sign is identical to the zero-fill left shift, so it has no separate code.

The shifter is one barrel of four cascaded stages. Each stage moves the word by a fixed power of two (1, 2, 4 and 8). A stage is active when its bit of the shift distance is set. An active stage uses a 4-way selector to pick the left-shifted, right-shifted, sign-filled or unshifted form of its input. An idle stage passes its input through. All three shift kinds share these four stages, so the block needs no separate barrel for each kind.

Top module: `bshift_core`

## Requirements
- R1: When `shop` is 2'b00, `c_out` equals `a_in` for every value of `shamt`.
- R2: When `shop` is 2'b01, `c_out` equals `a_in` shifted left by `shamt`, and the low `shamt` bits are zero.
- R3: When `shop` is 2'b10, `c_out` equals `a_in` shifted right by `shamt`, and the high `shamt` bits are zero.
- R4: When `shop` is 2'b11, `c_out` equals `a_in` shifted right by `shamt`, and the high `shamt` bits are copies of `a_in[15]`.
- R5: When `shamt` is 0, `c_out` equals `a_in` in every mode.
- R6: At the largest distance (15), a left shift leaves only `a_in[0]` in bit 15 and zeros elsewhere. A sign-filling right shift gives sixteen copies of `a_in[15]`.
- R7: The output depends only on the present inputs. A new input word presented on consecutive cycles produces its own result with no latency and no influence from the word before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | Data word to be shifted |
| shamt | input | 4 | Shift distance, 0 to 15 |
| shop | input | 2 | Operation: 00 pass, 01 left, 10 right zero fill, 11 right sign fill |
| c_out | output | 16 | Shifted result |

## Verification
The block holds no state, so any fault shows at the output for the very input pattern that exercises it. A wrongly wired stage corrupts only the distances whose bit selects that stage. A selector leg swapped between kinds corrupts only the matching operation code. The bench covers every distance for each operation code over several data words. It uses words with the sign bit clear and set, so a fill fault or a stage fault appears as a mismatch on the first input that reaches it.

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int WIDTH = 16,
  parameter int AMTW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [AMTW-1:0]  shamt,
  input  logic [1:0]       shop,
  output logic [WIDTH-1:0] c_out
);

  localparam int NSTAGE = AMTW;
  localparam logic [1:0] OP_PASS = 2'b00;
  localparam logic [1:0] OP_LSL  = 2'b01;
  localparam logic [1:0] OP_LSR  = 2'b10;
  localparam logic [1:0] OP_ASR  = 2'b11;

  function automatic logic [WIDTH-1:0] pick4(
    input logic [1:0] op, input logic [WIDTH-1:0] keep,
    input logic [WIDTH-1:0] lft, input logic [WIDTH-1:0] rgt,
    input logic [WIDTH-1:0] sgn);
    case (op)
      OP_LSL:  pick4 = lft;
      OP_LSR:  pick4 = rgt;
      OP_ASR:  pick4 = sgn;
      default: pick4 = keep;
    endcase
  endfunction

  logic [NSTAGE:0][WIDTH-1:0] stg;
  assign stg[0] = a_in;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [WIDTH-1:0] sl, sr, sa;
    assign sl = stg[k] << DIST;
    assign sr = stg[k] >> DIST;
    assign sa = $signed(stg[k]) >>> DIST;
    assign stg[k+1] = shamt[k] ? pick4(shop, stg[k], sl, sr, sa) : stg[k];
  end

  assign c_out = stg[NSTAGE];

  logic [WIDTH-1:0] lo_mask, hi_mask;
  assign lo_mask = ~({WIDTH{1'b1}} << shamt);
  assign hi_mask = ~({WIDTH{1'b1}} >> shamt);

  always_comb begin
    if (shop == OP_PASS) AST_PASS_MODE: assert (c_out == a_in); // R1
    if (shop == OP_LSL) AST_LSL_LOW_ZERO: assert ((c_out & lo_mask) == '0); // R2
    if (shop == OP_LSR) AST_LSR_HIGH_ZERO: assert ((c_out & hi_mask) == '0); // R3
    if (shop == OP_ASR)
      AST_ASR_SIGN_FILL: assert (((c_out ^ {WIDTH{a_in[WIDTH-1]}}) & hi_mask) == '0); // R4
    if (shamt == '0) AST_ZERO_DIST: assert (c_out == a_in); // R5
    if (shamt == '1 && shop == OP_LSL)
      AST_MAX_LEFT: assert (c_out == (WIDTH'(a_in[0]) << (WIDTH - 1))); // R6
  end

endmodule

// File: tb/test_bshift_core.sv
module test_bshift_core;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] a;
    logic [3:0]  n;
    logic [1:0]  op;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0;
  logic [3:0]  shamt = '0;
  logic [1:0]  shop = '0;
  logic [15:0] c_out;
  item_t       sbq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  bshift_core i_bshift_core (.a_in(a_in), .shamt(shamt), .shop(shop), .c_out(c_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(logic [15:0] a, logic [3:0] n, logic [1:0] op);
    case (op)
      2'b01:   return a << n;
      2'b10:   return a >> n;
      2'b11:   return 16'($signed(a) >>> n);
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] n, logic [1:0] op);
    if (n == 0) return "R5";
    if (n == 15 && (op == 2'b01 || op == 2'b11)) return "R6";
    case (op)
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(logic [15:0] a, logic [3:0] n, logic [1:0] op, string tag);
    item_t it;
    @(posedge clk);
    a_in = a; shamt = n; shop = op;
    it.a = a; it.n = n; it.op = op; it.exp = model(a, n, op);
    it.tag = (tag == "") ? tag_of(n, op) : tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      item_t it;
      it = sbq.pop_front();
      n_cmp++;
      if (c_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s: a=%h n=%0d op=%b got %h expected %h",
                 it.tag, it.a, it.n, it.op, c_out, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [6];
    pats[0] = 16'h0FF0; pats[1] = 16'hF00F; pats[2] = 16'h8001;
    pats[3] = 16'h7FFE; pats[4] = 16'hA5C3; pats[5] = 16'hFFFF;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(16'h0000, 4'd0, 2'b00, "R5");
    for (int op = 0; op < 4; op++) begin
      drive(16'h0FF0, 4'd4, 2'(op), "");
      drive(16'h0FF0, 4'd9, 2'(op), "");
      drive(16'hF00F, 4'd4, 2'(op), "");
      drive(16'hF00F, 4'd9, 2'(op), "");
    end
    for (int p = 0; p < 6; p++)
      for (int op = 0; op < 4; op++)
        for (int n = 0; n < 16; n++)
          drive(pats[p], 4'(n), 2'(op), "");
    drive(16'h8000, 4'd15, 2'b11, "R6");
    drive(16'h0001, 4'd15, 2'b01, "R6");
    drive(16'hFFFE, 4'd15, 2'b01, "R6");
    drive(16'h7FFF, 4'd15, 2'b11, "R6");
    drive(16'hFFFF, 4'd3, 2'b11, "R7");
    drive(16'h0000, 4'd3, 2'b11, "R7");
    drive(16'h1234, 4'd8, 2'b01, "R7");
    drive(16'h1234, 4'd8, 2'b10, "R7");
    for (int i = 0; i < 400; i++)
      drive(16'($urandom), 4'($urandom), 2'($urandom), "");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule